// File: doc/BRIEF.md
# Pulse Capture Edge Latch

This block times pulses on one capture input against a free-running down counter. The counter starts at all ones and steps down once per prescaler tick. The prescaler divides the clock by its programmed divider value plus one. The capture input passes through a two-flop synchroniser and then an edge detector. A rising edge copies the counter into the rising-latch register, and a falling edge copies it into the falling-latch register. Each edge also sets its own bit in a 2-bit flag code. Subtracting two latched values gives the pulse high time or low time in ticks.

Software clears each flag by pulsing a write-one strobe. Each flag can raise the interrupt line through its own enable. A transfer request port feeds an external DMA engine. It can hand over the rising value only, the falling value only, or both values as an ordered pair. In paired mode, an ordering input picks which edge leads the pair.

Top module: `pulse_capture_unit`

## Requirements
- R1: After reset, `timer_val` is 0xFFFF. `rise_val`, `fall_val`, `flags`, `irq` and `xfer_req` are all 0.
- R2: While capture runs, `timer_val` counts down by one per tick and wraps from 0 to 0xFFFF. A tick occurs once every `div_sel`+1 clocks, and the first tick comes on the `div_sel`+1-th clock edge after capture starts.
- R3: A rising edge on `cap_in` copies the counter value into `rise_val` and sets `flags` bit 0. A falling edge copies it into `fall_val` and sets `flags` bit 1. The copy becomes visible after the third clock edge following the input change.
- R4: Capture runs only while both `in_en` and `cap_en` are 1. Otherwise no edge is latched, no flag is set, and `timer_val` is held at 0xFFFF with the prescaler phase reset.
- R5: A 1 on `rise_clr` clears `flags` bit 0, and a 1 on `fall_clr` clears bit 1. If an edge of the same kind is latched in the same cycle as its clear, the flag stays set.
- R6: A new edge overwrites its latch register even while the matching flag is still set.
- R7: `irq` is 1 exactly when (`flags`[0] and `rise_ie`) or (`flags`[1] and `fall_ie`).
- R8: `xfer_mode` 2'b01 makes `xfer_req` pulse for one cycle per rising latch, and 2'b10 does the same per falling latch. In both cases `xfer_data` equals the latched value. 2'b00 never requests.
- R9: With `xfer_mode` 2'b11 and `fall_first` 0, a rising latch arms the unit. The next falling latch then gives two request pulses on consecutive cycles: the rising value first, then the falling value. With `fall_first` 1 the roles of the two edges swap. A trailing edge that arrives while the unit is unarmed gives no request.
- R10: For a high time of H clocks, `rise_val` minus `fall_val` (mod 2^16) is H/(`div_sel`+1) when H is a multiple of `div_sel`+1. The same holds for low times, measured from the falling latch to the next rising latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture input |
| in_en | input | 1 | Input path enable |
| cap_en | input | 1 | Capture function enable |
| div_sel | input | 12 | Prescaler divider minus one |
| rise_ie | input | 1 | Interrupt enable for the rising flag |
| fall_ie | input | 1 | Interrupt enable for the falling flag |
| rise_clr | input | 1 | Write-one clear of the rising flag |
| fall_clr | input | 1 | Write-one clear of the falling flag |
| xfer_mode | input | 2 | Transfer request mode: 00 off, 01 rising, 10 falling, 11 pair |
| fall_first | input | 1 | In pair mode, 1 puts the falling value first |
| timer_val | output | 16 | Current down-counter value |
| rise_val | output | 16 | Last rising-edge latch |
| fall_val | output | 16 | Last falling-edge latch |
| flags | output | 2 | Bit 0 rising latched, bit 1 falling latched |
| irq | output | 1 | Interrupt line |
| xfer_req | output | 1 | One-cycle transfer request |
| xfer_data | output | 16 | Value carried by the request |

## Verification
Pulse trains are run with several mixes of high time, low time and divider. Matching latch differences to H/(divider+1) separates the prescaler phase from the latch path, and a wrong tick period or an off-by-one divider shows up as a wrong difference. One absolute check, with the input edge and the enable arriving in the same cycle, pins the synchroniser latency to three edges. Edge orderings that start on the trailing edge show whether the pair sequencer ignores an unarmed trailing edge and whether it respects the ordering input. A clear arriving in the same cycle as a new edge shows which of the two wins.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_RISE = 2'b01,
    XFER_FALL = 2'b10,
    XFER_BOTH = 2'b11
  } xfer_mode_t;

  // next value of a sticky flag: a fresh event wins over a clear strobe
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/pcap_prescaler.sv
module pcap_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] div_sel,
  output logic             tick
);

  logic [PSC_W-1:0] phase;

  // a limit lowered below the current phase still ends the period at once
  function automatic logic period_end(input logic [PSC_W-1:0] ph, input logic [PSC_W-1:0] lim);
    return ph >= lim;
  endfunction

  logic at_end;
  assign at_end = period_end(phase, div_sel);
  assign tick   = run & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run || at_end) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count <= TOP;
    end else if (tick) begin
      count <= step_down(count);
    end
  end

endmodule

// File: rtl/pcap_edge_sync.sv
module pcap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic arm,
  output logic rise_evt,
  output logic fall_evt
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], din};
      prev  <= chain[SYNC_STAGES-1];
    end
  end

  assign rise_evt = arm &  chain[SYNC_STAGES-1] & ~prev;
  assign fall_evt = arm & ~chain[SYNC_STAGES-1] &  prev;

endmodule

// File: rtl/pcap_xfer_seq.sv
module pcap_xfer_seq
  import pcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_t       mode,
  input  logic             fall_first,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] count,
  output logic             req,
  output logic [CNT_W-1:0] data
);

  logic             armed;
  logic             pend;
  logic [CNT_W-1:0] held;
  logic [CNT_W-1:0] pend_val;

  logic lead_evt, trail_evt, single_hit, pair_hit;

  assign lead_evt   = fall_first ? fall_evt : rise_evt;
  assign trail_evt  = fall_first ? rise_evt : fall_evt;
  assign single_hit = ((mode == XFER_RISE) && rise_evt) || ((mode == XFER_FALL) && fall_evt);
  assign pair_hit   = (mode == XFER_BOTH) && trail_evt && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      data     <= '0;
      armed    <= 1'b0;
      pend     <= 1'b0;
      held     <= '0;
      pend_val <= '0;
    end else begin
      req <= 1'b0;
      if (pend) begin
        req  <= 1'b1;
        data <= pend_val;
        pend <= 1'b0;
      end else if (single_hit) begin
        req  <= 1'b1;
        data <= count;
      end else if (pair_hit) begin
        req      <= 1'b1;
        data     <= held;
        pend     <= 1'b1;
        pend_val <= count;
      end

      if (mode != XFER_BOTH) begin
        armed <= 1'b0;
      end else if (lead_evt) begin
        armed <= 1'b1;
        held  <= count;
      end else if (pair_hit && !pend) begin
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
  import pcap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic             in_en,
  input  logic             cap_en,
  input  logic [PSC_W-1:0] div_sel,
  input  logic             rise_ie,
  input  logic             fall_ie,
  input  logic             rise_clr,
  input  logic             fall_clr,
  input  logic [1:0]       xfer_mode,
  input  logic             fall_first,
  output logic [CNT_W-1:0] timer_val,
  output logic [CNT_W-1:0] rise_val,
  output logic [CNT_W-1:0] fall_val,
  output logic [1:0]       flags,
  output logic             irq,
  output logic             xfer_req,
  output logic [CNT_W-1:0] xfer_data
);

  // named internal events, also observed by the bound checker
  logic run;
  logic tick;
  logic rise_evt;
  logic fall_evt;

  assign run = in_en & cap_en;

  pcap_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_sel (div_sel),
    .tick    (tick)
  );

  pcap_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .count (timer_val)
  );

  pcap_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (cap_in),
    .arm      (run),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_val <= '0;
      fall_val <= '0;
      flags    <= 2'b00;
    end else begin
      if (rise_evt) rise_val <= timer_val;
      if (fall_evt) fall_val <= timer_val;
      flags[0] <= flag_next(flags[0], rise_evt, rise_clr);
      flags[1] <= flag_next(flags[1], fall_evt, fall_clr);
    end
  end

  assign irq = (flags[0] & rise_ie) | (flags[1] & fall_ie);

  pcap_xfer_seq #(.CNT_W(CNT_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (xfer_mode_t'(xfer_mode)),
    .fall_first (fall_first),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .count      (timer_val),
    .req        (xfer_req),
    .data       (xfer_data)
  );

endmodule

// File: rtl/pulse_capture_chk.sv
module pulse_capture_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             rise_clr,
  input logic             fall_clr,
  input logic             rise_ie,
  input logic             fall_ie,
  input logic [1:0]       xfer_mode,
  input logic             xfer_req,
  input logic [CNT_W-1:0] timer_val,
  input logic [CNT_W-1:0] rise_val,
  input logic [CNT_W-1:0] fall_val,
  input logic [1:0]       flags,
  input logic             irq
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick |=> timer_val == CNT_W'($past(timer_val) - 1'b1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(timer_val));

  p_rise_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (rise_val == $past(timer_val)) && flags[0]);

  p_fall_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (fall_val == $past(timer_val)) && flags[1]);

  p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (timer_val == '1) && $stable(rise_val) && $stable(fall_val));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt && rise_clr |=> flags[0]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_clr && !fall_evt |=> !flags[1]);

  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && rise_ie) || (flags[1] && fall_ie) |-> irq);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[0] && rise_ie) && !(flags[1] && fall_ie) |-> !irq);

  p_xfer_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_mode == 2'b00) && ($past(xfer_mode) == 2'b00) && ($past(xfer_mode, 2) == 2'b00)
      |-> !xfer_req);

endmodule

bind pulse_capture_unit pulse_capture_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/pulse_capture_unit_test.sv
module pulse_capture_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_in, in_en, cap_en;
  logic [11:0] div_sel;
  logic        rise_ie, fall_ie, rise_clr, fall_clr;
  logic [1:0]  xfer_mode;
  logic        fall_first;
  logic [15:0] timer_val, rise_val, fall_val, xfer_data;
  logic [1:0]  flags;
  logic        irq, xfer_req;

  always #2 clk = ~clk;

  pulse_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .in_en(in_en), .cap_en(cap_en),
    .div_sel(div_sel), .rise_ie(rise_ie), .fall_ie(fall_ie),
    .rise_clr(rise_clr), .fall_clr(fall_clr), .xfer_mode(xfer_mode),
    .fall_first(fall_first), .timer_val(timer_val), .rise_val(rise_val),
    .fall_val(fall_val), .flags(flags), .irq(irq), .xfer_req(xfer_req),
    .xfer_data(xfer_data)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {high clocks, low clocks, divider, expected high ticks, expected low ticks}
  localparam int VEC_N = 6;
  localparam int VEC [VEC_N][5] = '{
    '{5,  7,  0, 5,  7},
    '{20, 3,  0, 20, 3},
    '{12, 12, 1, 6,  6},
    '{9,  30, 2, 3,  10},
    '{40, 8,  3, 10, 2},
    '{16, 16, 7, 2,  2}
  };

  logic [15:0] xlog [16];
  int          log_n = 0;

  always @(negedge clk) begin
    if (xfer_req) begin
      if (log_n < 16) xlog[log_n] = xfer_data;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    rise_clr = 1'b1; fall_clr = 1'b1;
    tk(1);
    rise_clr = 1'b0; fall_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r1, f1, d;
    int          base;
    rst_n = 1'b0; cap_in = 1'b0; in_en = 1'b0; cap_en = 1'b0; div_sel = '0;
    rise_ie = 1'b0; fall_ie = 1'b0; rise_clr = 1'b0; fall_clr = 1'b0;
    xfer_mode = 2'b00; fall_first = 1'b0;
    tk(5);
    rst_n = 1'b1;
    tk(1);
    // R1 reset state
    chk("R1 timer", timer_val, 16'hFFFF);
    chk("R1 latches", {rise_val, fall_val}, 32'h0);
    chk("R1 flags/irq/req", {flags, irq, xfer_req}, 4'b0000);

    // R4: a single enable is not enough
    cap_in = 1'b1; tk(6); cap_in = 1'b0; tk(6);
    chk("R4 none enabled", flags, 2'b00);
    in_en = 1'b1;
    cap_in = 1'b1; tk(6); cap_in = 1'b0; tk(6);
    chk("R4 input only", {flags, rise_val}, 18'h0);
    chk("R4 timer held", timer_val, 16'hFFFF);
    in_en = 1'b0; cap_en = 1'b1;
    cap_in = 1'b1; tk(6); cap_in = 1'b0; tk(6);
    chk("R4 function only", {flags, fall_val}, 18'h0);
    cap_en = 1'b0;

    // R2: count rate and prescaler
    in_en = 1'b1; cap_en = 1'b1; div_sel = 12'd0;
    tk(10);
    chk("R2 div0 count", timer_val, 16'hFFF5);
    in_en = 1'b0; tk(1);
    chk("R4 disable reloads", timer_val, 16'hFFFF);
    div_sel = 12'd3; in_en = 1'b1;
    tk(8);
    chk("R2 div3 count", timer_val, 16'hFFFD);

    // R3: absolute latch value and latency
    in_en = 1'b0; div_sel = 12'd0; tk(1);
    in_en = 1'b1; cap_in = 1'b1;
    tk(2);
    chk("R3 not yet latched", flags, 2'b00);
    tk(1);
    chk("R3 rise value", rise_val, 16'hFFFD);
    chk("R3 rise flag", flags, 2'b01);
    cap_in = 1'b0; tk(8);
    chk("R3 fall value", fall_val, 16'hFFFA);
    chk("R3 both flags", flags, 2'b11);

    // table: pulse widths against divider (R10, R6)
    for (int v = 0; v < VEC_N; v++) begin
      in_en = 1'b0; div_sel = 12'(VEC[v][2]);
      clear_flags();
      in_en = 1'b1; tk(3);
      cap_in = 1'b1; tk(VEC[v][0]);
      r1 = rise_val;
      cap_in = 1'b0; tk(VEC[v][1]);
      f1 = fall_val;
      cap_in = 1'b1; tk(4);
      d = r1 - f1;
      chk("R10 high ticks", d, VEC[v][3]);
      d = f1 - rise_val;
      chk("R10 low ticks", d, VEC[v][4]);
      d = r1 - 16'(VEC[v][3] + VEC[v][4]);
      chk("R6 overwrite while flagged", rise_val, d);
      cap_in = 1'b0; tk(4);
      chk("R3 flags after pulse", flags, 2'b11);
    end

    // R5: write-one clear and set-wins
    div_sel = 12'd0;
    rise_clr = 1'b1; tk(1); rise_clr = 1'b0;
    chk("R5 clear rising only", flags, 2'b10);
    fall_clr = 1'b1; tk(1); fall_clr = 1'b0;
    chk("R5 clear falling", flags, 2'b00);
    cap_in = 1'b1; tk(2);
    rise_clr = 1'b1; tk(1); rise_clr = 1'b0;
    chk("R5 set wins over clear", flags, 2'b01);
    rise_clr = 1'b1; tk(1); rise_clr = 1'b0;
    chk("R5 later clear", flags, 2'b00);

    // R7: interrupt gating
    rise_ie = 1'b1; fall_ie = 1'b1; tk(1);
    chk("R7 no flags", irq, 1'b0);
    cap_in = 1'b0; tk(5);
    chk("R7 fall flag enabled", irq, 1'b1);
    fall_ie = 1'b0; tk(1);
    chk("R7 fall flag masked", irq, 1'b0);
    cap_in = 1'b1; tk(5);
    chk("R7 rise flag enabled", irq, 1'b1);
    rise_ie = 1'b0; tk(1);
    chk("R7 all masked", irq, 1'b0);
    clear_flags();

    // R8: single-edge transfer modes
    xfer_mode = 2'b01; base = log_n;
    cap_in = 1'b0; tk(6); cap_in = 1'b1; tk(6);
    chk("R8 rise-only count", log_n - base, 1);
    chk("R8 rise-only data", xlog[base], rise_val);
    xfer_mode = 2'b10; base = log_n;
    cap_in = 1'b0; tk(6);
    chk("R8 fall-only data", xlog[base], fall_val);
    cap_in = 1'b1; tk(6);
    chk("R8 fall-only count", log_n - base, 1);
    xfer_mode = 2'b00; base = log_n;
    cap_in = 1'b0; tk(6); cap_in = 1'b1; tk(6);
    chk("R8 off count", log_n - base, 0);

    // R9: paired transfers, both orderings
    xfer_mode = 2'b11; fall_first = 1'b0; base = log_n;
    cap_in = 1'b0; tk(6);
    chk("R9 unarmed fall", log_n - base, 0);
    cap_in = 1'b1; tk(6);
    cap_in = 1'b0; tk(6);
    chk("R9 rise-first count", log_n - base, 2);
    chk("R9 rise-first first", xlog[base], rise_val);
    chk("R9 rise-first second", xlog[base + 1], fall_val);
    xfer_mode = 2'b00; tk(1);
    xfer_mode = 2'b11; fall_first = 1'b1; base = log_n;
    cap_in = 1'b1; tk(6);
    chk("R9 unarmed rise", log_n - base, 0);
    cap_in = 1'b0; tk(6);
    cap_in = 1'b1; tk(6);
    chk("R9 fall-first count", log_n - base, 2);
    chk("R9 fall-first first", xlog[base], fall_val);
    chk("R9 fall-first second", xlog[base + 1], rise_val);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule